// File: doc/BRIEF.md
# Transmit-Only Console Serial Port Stub

This block stands in for a 16550-class serial port in systems where boot firmware only ever prints to a console. It decodes a 32-bit register port whose registers sit on a four-byte stride. Only the low eight address bits are decoded. A write to the transmit-holding offset hands its low byte to a character output stream. Firmware that programs a baud divisor first sets the divisor-latch access bit in the line-control register. While that bit is set, writes to the holding offset are divisor values and emit nothing.

There is no serial bit timing, no receive path, no FIFO and no interrupt. The line-status register always reports an empty transmitter, so firmware that polls before each character never stalls. The character output is a valid/ready stream. A character appears in the same cycle as the write that carries it. If the sink holds `tx_ready` low, the block holds `bus_wr_ready` low for that write. The bus master must keep address and data steady until the write is accepted, and `tx_valid` and `tx_data` stay steady with them. Only a character write can be back-pressured. Every other write, and every read, completes in its own cycle.

Top module: `uart_tx_stub`

## Requirements
- R1: After reset the divisor-latch access bit is clear, so the first write to offset 0x00 emits a character.
- R2: A write to offset 0x00 while the divisor-latch bit is clear raises `tx_valid` in the same cycle, with `tx_data` equal to `bus_wdata[7:0]`. Bits 31:8 of the write data have no effect.
- R3: A write to offset 0x0C loads `bus_wdata[7]` into the divisor-latch bit, and all other data bits are ignored. The new value governs writes from the next cycle on.
- R4: While the divisor-latch bit is set, a write to offset 0x00 is accepted (`bus_wr_ready` high) and produces no `tx_valid`.
- R5: A read with offset 0x10 returns 32'h0000_0003 on `bus_rdata` in the same cycle.
- R6: A read with offset 0x14 (line status) returns 32'h0000_0060, meaning the holding register and the transmitter are empty.
- R7: A read of any other offset returns 0. `bus_rdata` is 0 whenever `bus_rd` is low.
- R8: Only `bus_addr[7:0]` selects a register, and higher address bits have no effect.
- R9: A character write while `tx_ready` is low sees `bus_wr_ready` low, keeps `tx_valid` high and changes no state. All writes not emitting a character see `bus_wr_ready` high.
- R10: Writes to offsets other than 0x00 and 0x0C produce no character and leave the divisor-latch bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register byte address; low 8 bits decoded |
| bus_wr | input | 1 | Write request |
| bus_wdata | input | 32 | Write data |
| bus_wr_ready | output | 1 | Write accepted this cycle when high |
| bus_rd | input | 1 | Read request |
| bus_rdata | output | 32 | Read data, same cycle as `bus_rd` |
| tx_data | output | 8 | Character byte |
| tx_valid | output | 1 | Character present |
| tx_ready | input | 1 | Sink accepts the character |

## Verification
Character output, write-ready and read data are all combinational from the current request. Each is therefore due in the cycle the request is driven. The bench drives inputs just after a rising edge and compares all three at the following falling edge. The divisor-latch bit is the only state. A line-control write takes effect from the next edge, so the reference model updates its copy of that bit only after the comparison, and the next write is judged against the new value.

// File: rtl/uart_stub_pkg.sv
package uart_stub_pkg;
  localparam int REG_W    = 32;
  localparam int CHAR_W   = 8;
  localparam int DECODE_W = 8;
  localparam int LATCH_BIT = 7;

  localparam logic [DECODE_W-1:0] OFS_HOLD  = 8'h00;
  localparam logic [DECODE_W-1:0] OFS_LCTL  = 8'h0C;
  localparam logic [DECODE_W-1:0] OFS_MCTL  = 8'h10;
  localparam logic [DECODE_W-1:0] OFS_LSTAT = 8'h14;

  localparam logic [REG_W-1:0] MCTL_VALUE  = 32'h0000_0003;
  localparam logic [REG_W-1:0] LSTAT_VALUE = 32'h0000_0060;

  typedef enum logic [2:0] {
    SEL_HOLD,
    SEL_LCTL,
    SEL_MCTL,
    SEL_LSTAT,
    SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/uart_stub_decode.sv
module uart_stub_decode
  import uart_stub_pkg::*;
(
  input  logic [DECODE_W-1:0] offset,
  output reg_sel_e            sel
);
  always_comb begin
    case (offset)
      OFS_HOLD:  sel = SEL_HOLD;
      OFS_LCTL:  sel = SEL_LCTL;
      OFS_MCTL:  sel = SEL_MCTL;
      OFS_LSTAT: sel = SEL_LSTAT;
      default:   sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/uart_stub_latch.sv
module uart_stub_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic load_val,
  output logic latch_on
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    latch_on <= 1'b0;
    else if (load) latch_on <= load_val;
  end
endmodule

// File: rtl/uart_stub_txgate.sv
module uart_stub_txgate
  import uart_stub_pkg::*;
(
  input  reg_sel_e          sel,
  input  logic              wr,
  input  logic              latch_on,
  input  logic [CHAR_W-1:0] byte_in,
  input  logic              sink_ready,
  output logic [CHAR_W-1:0] char_out,
  output logic              char_valid,
  output logic              wr_ready
);
  logic targets_char;

  always_comb begin
    targets_char = (sel == SEL_HOLD) && !latch_on;
    char_valid   = wr && targets_char;
    char_out     = byte_in;
    wr_ready     = !targets_char || sink_ready;
  end
endmodule

// File: rtl/uart_stub_readmux.sv
module uart_stub_readmux
  import uart_stub_pkg::*;
(
  input  reg_sel_e         sel,
  input  logic             rd,
  output logic [REG_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (rd) begin
      case (sel)
        SEL_MCTL:  rdata = MCTL_VALUE;
        SEL_LSTAT: rdata = LSTAT_VALUE;
        default:   rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx_stub.sv
module uart_tx_stub
  import uart_stub_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic              bus_wr_ready,
  input  logic              bus_rd,
  output logic [REG_W-1:0]  bus_rdata,
  output logic [CHAR_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic              tx_ready
);
  reg_sel_e sel;
  logic     latch_on;
  logic     latch_load;
  logic     unused_bits;

  assign unused_bits = ^{bus_addr[ADDR_W-1:DECODE_W], bus_wdata[REG_W-1:CHAR_W]};

  uart_stub_decode u_decode (
    .offset (bus_addr[DECODE_W-1:0]),
    .sel    (sel)
  );

  assign latch_load = bus_wr && (sel == SEL_LCTL);

  uart_stub_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (latch_load),
    .load_val (bus_wdata[LATCH_BIT]),
    .latch_on (latch_on)
  );

  uart_stub_txgate u_txgate (
    .sel        (sel),
    .wr         (bus_wr),
    .latch_on   (latch_on),
    .byte_in    (bus_wdata[CHAR_W-1:0]),
    .sink_ready (tx_ready),
    .char_out   (tx_data),
    .char_valid (tx_valid),
    .wr_ready   (bus_wr_ready)
  );

  uart_stub_readmux u_readmux (
    .sel   (sel),
    .rd    (bus_rd),
    .rdata (bus_rdata)
  );
endmodule

// File: rtl/uart_tx_stub_chk.sv
module uart_tx_stub_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic              bus_wr_ready,
  input logic              bus_rd,
  input logic [31:0]       bus_rdata,
  input logic [7:0]        tx_data,
  input logic              tx_valid,
  input logic              tx_ready
);
  logic [7:0] ofs;
  logic       unused_hi;
  assign ofs = bus_addr[7:0];
  assign unused_hi = ^bus_addr[ADDR_W-1:8];

  // R2
  char_needs_hold_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (bus_wr && ofs == 8'h00));

  // R2
  char_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_data == bus_wdata[7:0]));

  // R3
  latch_clear_allows_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_wr && ofs == 8'h0C && !bus_wdata[7]) && bus_wr && ofs == 8'h00) |-> tx_valid);

  // R4
  latch_set_blocks_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_wr && ofs == 8'h0C && bus_wdata[7]) && bus_wr && ofs == 8'h00)
      |-> (!tx_valid && bus_wr_ready));

  // R5
  mctl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && ofs == 8'h10) |-> (bus_rdata == 32'h3));

  // R6
  lstat_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && ofs == 8'h14) |-> (bus_rdata == 32'h60));

  // R7
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == 32'h0));

  // R9
  stall_only_on_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_wr_ready) |-> (tx_valid && !tx_ready));

  // R10
  other_write_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && ofs != 8'h00) |-> (!tx_valid && bus_wr_ready));
endmodule

bind uart_tx_stub uart_tx_stub_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_addr     (bus_addr),
  .bus_wr       (bus_wr),
  .bus_wdata    (bus_wdata),
  .bus_wr_ready (bus_wr_ready),
  .bus_rd       (bus_rd),
  .bus_rdata    (bus_rdata),
  .tx_data      (tx_data),
  .tx_valid     (tx_valid),
  .tx_ready     (tx_ready)
);

// File: tb/tb_uart_tx_stub.sv
`timescale 1ns/1ps
module tb_uart_tx_stub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr_ready;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b1;

  int tests = 0;
  int fails = 0;
  bit model_latch = 1'b0;

  always #2.5 clk = ~clk;

  uart_tx_stub #(.ADDR_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_wr_ready(bus_wr_ready), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One cycle: drive, compare against reference at the falling edge, update model.
  task automatic step(input string req, input logic [31:0] a, input logic w,
                      input logic [31:0] d, input logic r, input logic trdy);
    logic [7:0]  o;
    logic        exp_valid, exp_ready;
    logic [31:0] exp_rdata;
    bus_addr = a; bus_wr = w; bus_wdata = d; bus_rd = r; tx_ready = trdy;
    o = a[7:0];
    exp_valid = w && (o == 8'h00) && !model_latch;
    exp_ready = !((o == 8'h00) && !model_latch) || trdy;
    if (!r)               exp_rdata = 32'h0;
    else if (o == 8'h10)  exp_rdata = 32'h3;
    else if (o == 8'h14)  exp_rdata = 32'h60;
    else                  exp_rdata = 32'h0;
    @(negedge clk);
    check(req, "tx_valid", {31'b0, tx_valid}, {31'b0, exp_valid});
    check(req, "bus_wr_ready", {31'b0, bus_wr_ready}, {31'b0, exp_ready});
    check(req, "bus_rdata", bus_rdata, exp_rdata);
    if (exp_valid) check(req, "tx_data", {24'b0, tx_data}, {24'b0, d[7:0]});
    if (w && o == 8'h0C) model_latch = d[7];
    @(posedge clk);
    #1;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state: idle outputs
    check("R1", "reset tx_valid", {31'b0, tx_valid}, 32'h0);
    check("R1", "reset rdata", bus_rdata, 32'h0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    step("R1", 32'h0, 1, 32'h41, 0, 1);
    // R2 upper data bits ignored
    step("R2", 32'h0, 1, 32'hDEADBE42, 0, 1);
    step("R2", 32'h0, 1, 32'h000000FF, 0, 1);
    // R9 back-pressure: held write, then accepted
    step("R9", 32'h0, 1, 32'h55, 0, 0);
    step("R9", 32'h0, 1, 32'h55, 0, 0);
    step("R9", 32'h0, 1, 32'h55, 0, 1);
    step("R9", 32'h0C, 1, 32'h00, 0, 0);
    // R3 / R4 divisor latch
    step("R3", 32'h0C, 1, 32'hFFFFFF80, 0, 1);
    step("R4", 32'h0, 1, 32'h0C, 0, 1);
    step("R4", 32'h0, 1, 32'h00, 0, 0);
    step("R4", 32'h04, 1, 32'h00, 0, 1);
    step("R3", 32'h0C, 1, 32'h0000007F, 0, 1);
    step("R3", 32'h0, 1, 32'h43, 0, 1);
    // R5 R6 R7 reads
    step("R5", 32'h10, 0, 32'h0, 1, 1);
    step("R6", 32'h14, 0, 32'h0, 1, 1);
    step("R7", 32'h04, 0, 32'h0, 1, 1);
    step("R7", 32'h08, 0, 32'h0, 1, 1);
    step("R7", 32'h18, 0, 32'h0, 1, 1);
    step("R7", 32'h11, 0, 32'h0, 1, 1);
    step("R7", 32'hFF, 0, 32'h0, 1, 1);
    step("R7", 32'h0C, 0, 32'h0, 1, 1);
    // R8 high address bits ignored
    step("R8", 32'hABCD0014, 0, 32'h0, 1, 1);
    step("R8", 32'h12345600, 1, 32'h61, 0, 1);
    step("R8", 32'h8000010C, 1, 32'h80, 0, 1);
    step("R8", 32'hFFFFFF00, 1, 32'h62, 0, 1);
    step("R8", 32'h0000FF0C, 1, 32'h00, 0, 1);
    // R10 other offsets: no char, latch untouched
    step("R10", 32'h04, 1, 32'h80, 0, 1);
    step("R10", 32'h10, 1, 32'h80, 0, 0);
    step("R10", 32'h14, 1, 32'hFF, 0, 1);
    step("R10", 32'h0D, 1, 32'h80, 0, 1);
    step("R10", 32'h0, 1, 32'h44, 0, 1);
    // Mixed traffic against the model
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      logic [2:0]  pick;
      pick = 3'($urandom_range(0, 5));
      case (pick)
        3'd0: a = 32'h00;
        3'd1: a = 32'h0C;
        3'd2: a = 32'h10;
        3'd3: a = 32'h14;
        3'd4: a = 32'h08;
        default: a = 32'h0000_0100 * $urandom_range(0, 3);
      endcase
      a[31:8] = 24'($urandom);
      step("R2", a, 1'($urandom), $urandom, 1'($urandom), 1'($urandom));
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule